// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block picks the integer dividers for a frequency synthesizer. A caller presents a reference frequency, a wanted output frequency, the highest and lowest allowed oscillator frequencies, the allowed ranges of the input divider M and the feedback divider N, and the largest post shift P. A single-cycle start pulse latches all of these inputs. The engine then walks a bounded search and reports the M, N and P it chose, along with the oscillator frequency that choice gives.

The search first scales the target up by powers of two, as far as the oscillator ceiling allows. It then works back down one post-shift step at a time. At each step it tries every M in range, computes N in closed form with rounding, and keeps the candidate whose oscillator frequency lies nearest the scaled target. The acceptance threshold is halved at every step down, so a lower post shift must do proportionally better to displace an earlier choice. All divisions run through one shared restoring divider that produces one quotient bit per cycle. The control sequencer waits while the divider works.

All frequency arithmetic is unsigned and 32 bits wide, and the reference frequency must be non-zero.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, busy and done are 0 and m_sel, n_sel, p_sel and vco_khz are all 0.
- R2: Before searching, the target is doubled and a counter P that starts at 1 is incremented with each doubling. Doubling continues while P is at most p_max and twice the current target, computed exactly, does not exceed fmax_khz.
- R3: After doubling, the scaled target is raised to vco_min_khz if it is below that value, and is then lowered to fmax_khz if it is above that value.
- R4: For each M from m_lo to m_hi, N = floor((target*(M+1) + floor(ref/2)) / ref) - 1, with all terms taken modulo 2^32. If N exceeds n_hi, the remaining M values of that pass are skipped. If N is below n_lo, N becomes n_lo.
- R5: A candidate's oscillator frequency is floor(ref*(N+1)/(M+1)) modulo 2^32. Its error is the absolute difference between that frequency and the current target.
- R6: The best error starts at all ones. A candidate replaces the stored result only if its error is strictly smaller than the best error. After every pass, both the target and the best error are shifted right by one.
- R7: Each pass first checks P. If P is 0 the search ends; otherwise P is decremented. The pass then ends the search if the target is below vco_min_khz. The reported p_sel is the decremented P of the pass in which the kept candidate was found.
- R8: done stays high and the outputs stay unchanged until the next accepted start. A start that arrives while busy is high is ignored.
- R9: If no candidate is ever accepted, including when m_lo > m_hi, the engine finishes with m_sel, n_sel, p_sel and vco_khz all 0.
- R10: In the cycle after an accepted start, busy is 1 and done is 0. busy stays high until done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request; latches all configuration inputs |
| ref_khz | input | 32 | Reference frequency, non-zero |
| target_khz | input | 32 | Wanted output frequency |
| fmax_khz | input | 32 | Highest allowed oscillator frequency |
| vco_min_khz | input | 32 | Lowest allowed oscillator frequency |
| m_lo | input | M_W | Smallest input divider value |
| m_hi | input | M_W | Largest input divider value |
| n_lo | input | N_W | Smallest feedback divider value |
| n_hi | input | N_W | Largest feedback divider value |
| p_max | input | P_W | Largest post shift |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid; held until the next start |
| m_sel | output | M_W | Chosen input divider |
| n_sel | output | N_W | Chosen feedback divider |
| p_sel | output | P_W | Chosen post shift |
| vco_khz | output | 32 | Oscillator frequency of the chosen dividers |

## Verification
Internal state in this block shows at the ports only once, when done rises. Errors in the scaling count, the rounding of N, or the halving of the threshold all surface as a wrong M, N, P or frequency in that one result. The bench therefore compares every field of every result against an independent model of the search. The cases are chosen so that each branch decides the outcome: a clamp at either bound, a forced minimum N, an empty or overflowing divider range, and a start that must be ignored. A stuck or mis-sequenced controller shows as done never rising or rising too soon. A fault in the hold logic shows as a result that changes in the idle cycles after done.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    // Width of every frequency value and of the shared divider
    localparam int unsigned FREQ_W = 32;

    typedef logic [FREQ_W-1:0] freq_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCALE,
        ST_CLAMP,
        ST_OUTER,
        ST_NGO,
        ST_NWAIT,
        ST_VGO,
        ST_VWAIT,
        ST_STEP,
        ST_DONE
    } srch_state_e;

    // Unsigned distance between two frequencies
    function automatic freq_t freq_absdiff(input freq_t a, input freq_t b);
        return (a < b) ? (b - a) : (a - b);
    endfunction

    // Product truncated to the frequency width (modulo 2^FREQ_W)
    function automatic freq_t freq_mul(input freq_t a, input freq_t b);
        logic [2*FREQ_W-1:0] full;
        full = {{FREQ_W{1'b0}}, a} * {{FREQ_W{1'b0}}, b};
        return full[FREQ_W-1:0];
    endfunction

endpackage

// File: rtl/pll_div.sv
module pll_div
    import pll_search_pkg::*;
#(
    parameter int unsigned W = FREQ_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quot
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     dvd_q;
    logic [W-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic [W+1:0]     shifted;
    logic [W+1:0]     trial;

    // Bring down the next dividend bit and try one subtraction
    always_comb begin
        shifted = {1'b0, rem_q, quot[W-1]};
        trial   = shifted - {2'b00, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            dvd_q <= '0;
            dvs_q <= '0;
            quot  <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quot  <= dividend;
                dvd_q <= dividend;
                dvs_q <= divisor;
                cnt_q <= CNT_W'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (trial[W+1]) begin
                    rem_q <= shifted[W-1:0];
                    quot  <= {quot[W-2:0], 1'b0};
                end else begin
                    rem_q <= trial[W-1:0];
                    quot  <= {quot[W-2:0], 1'b1};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    // R4 R5: a finished quotient is the floor of dividend over divisor
    div_quot_chk: assert property (@(posedge clk) disable iff (rst)
        (fin && dvs_q != '0) |->
            (({{W{1'b0}}, quot} * {{W{1'b0}}, dvs_q} <= {{W{1'b0}}, dvd_q}) &&
             ({{W{1'b0}}, quot} * {{W{1'b0}}, dvs_q} + {{W{1'b0}}, dvs_q} > {{W{1'b0}}, dvd_q})));

endmodule

// File: rtl/pll_best_track.sv
module pll_best_track
    import pll_search_pkg::*;
#(
    parameter int unsigned M_W = 8,
    parameter int unsigned N_W = 8,
    parameter int unsigned P_W = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           halve,
    input  logic           cand_vld,
    input  freq_t          cand_err,
    input  logic [M_W-1:0] cand_m,
    input  logic [N_W-1:0] cand_n,
    input  logic [P_W-1:0] cand_p,
    input  freq_t          cand_vco,
    output freq_t          best_err,
    output logic [M_W-1:0] best_m,
    output logic [N_W-1:0] best_n,
    output logic [P_W-1:0] best_p,
    output freq_t          best_vco
);
    logic take;

    assign take = cand_vld && (cand_err < best_err);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best_err <= '1;
            best_m   <= '0;
            best_n   <= '0;
            best_p   <= '0;
            best_vco <= '0;
        end else if (take) begin
            best_err <= cand_err;
            best_m   <= cand_m;
            best_n   <= cand_n;
            best_p   <= cand_p;
            best_vco <= cand_vco;
        end else if (halve) begin
            best_err <= best_err >> 1;
        end
    end

    // R6: the threshold never grows within one search
    err_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> best_err <= $past(best_err));

    // R6: a candidate that is not strictly better leaves the result alone
    keep_best_chk: assert property (@(posedge clk) disable iff (rst)
        (cand_vld && !clr && cand_err >= best_err) |=>
            ($stable(best_vco) && $stable(best_m) && $stable(best_n) && $stable(best_p)));

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
    import pll_search_pkg::*;
#(
    parameter int unsigned M_W = 8,
    parameter int unsigned N_W = 8,
    parameter int unsigned P_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_khz,
    input  logic [FREQ_W-1:0] target_khz,
    input  logic [FREQ_W-1:0] fmax_khz,
    input  logic [FREQ_W-1:0] vco_min_khz,
    input  logic [M_W-1:0]    m_lo,
    input  logic [M_W-1:0]    m_hi,
    input  logic [N_W-1:0]    n_lo,
    input  logic [N_W-1:0]    n_hi,
    input  logic [P_W-1:0]    p_max,
    output logic              busy,
    output logic              done,
    output logic [M_W-1:0]    m_sel,
    output logic [N_W-1:0]    n_sel,
    output logic [P_W-1:0]    p_sel,
    output logic [FREQ_W-1:0] vco_khz
);
    localparam int unsigned MC_W = M_W + 1;
    localparam int unsigned PC_W = P_W + 1;

    typedef struct packed {
        freq_t          refk;
        freq_t          fmax;
        freq_t          vmin;
        logic [M_W-1:0] m_lo;
        logic [M_W-1:0] m_hi;
        logic [N_W-1:0] n_lo;
        logic [N_W-1:0] n_hi;
        logic [P_W-1:0] p_max;
    } cfg_t;

    srch_state_e     st;
    cfg_t            cfg;
    freq_t           fwant;
    logic [PC_W-1:0] p_cnt;
    logic [MC_W-1:0] m_cnt;
    freq_t           n_cur;

    logic  start_ok;
    logic  div_go, div_busy, div_fin;
    freq_t div_dvd, div_dvs, div_q;
    freq_t m_plus1, n_raw, cand_err, best_err, clamp_lo;
    logic  cand_vld, trk_halve;

    assign start_ok = start && (st == ST_IDLE || st == ST_DONE);
    assign m_plus1  = freq_t'(m_cnt) + freq_t'(1);
    assign n_raw    = div_q - freq_t'(1);
    assign clamp_lo = (fwant < cfg.vmin) ? cfg.vmin : fwant;

    // Shared divider operand selection
    always_comb begin
        div_go = (st == ST_NGO) || (st == ST_VGO);
        if (st == ST_VGO) begin
            div_dvd = freq_mul(cfg.refk, n_cur + freq_t'(1));
            div_dvs = m_plus1;
        end else begin
            div_dvd = freq_mul(fwant, m_plus1) + (cfg.refk >> 1);
            div_dvs = cfg.refk;
        end
    end

    assign cand_vld  = (st == ST_VWAIT) && div_fin;
    assign cand_err  = freq_absdiff(div_q, fwant);
    assign trk_halve = (st == ST_STEP);

    pll_div #(.W(FREQ_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .busy     (div_busy),
        .fin      (div_fin),
        .quot     (div_q)
    );

    pll_best_track #(.M_W(M_W), .N_W(N_W), .P_W(P_W)) u_best (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_ok),
        .halve    (trk_halve),
        .cand_vld (cand_vld),
        .cand_err (cand_err),
        .cand_m   (m_cnt[M_W-1:0]),
        .cand_n   (n_cur[N_W-1:0]),
        .cand_p   (p_cnt[P_W-1:0]),
        .cand_vco (div_q),
        .best_err (best_err),
        .best_m   (m_sel),
        .best_n   (n_sel),
        .best_p   (p_sel),
        .best_vco (vco_khz)
    );

    // Search sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cfg   <= '0;
            fwant <= '0;
            p_cnt <= '0;
            m_cnt <= '0;
            n_cur <= '0;
        end else begin
            unique case (st)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        cfg   <= '{refk: ref_khz, fmax: fmax_khz, vmin: vco_min_khz,
                                   m_lo: m_lo, m_hi: m_hi, n_lo: n_lo, n_hi: n_hi,
                                   p_max: p_max};
                        fwant <= target_khz;
                        p_cnt <= PC_W'(1);
                        st    <= ST_SCALE;
                    end
                end
                ST_SCALE: begin
                    if (p_cnt <= {1'b0, cfg.p_max} &&
                        {fwant, 1'b0} <= {1'b0, cfg.fmax}) begin
                        fwant <= fwant << 1;
                        p_cnt <= p_cnt + 1'b1;
                    end else begin
                        st <= ST_CLAMP;
                    end
                end
                ST_CLAMP: begin
                    fwant <= (clamp_lo > cfg.fmax) ? cfg.fmax : clamp_lo;
                    st    <= ST_OUTER;
                end
                ST_OUTER: begin
                    if (p_cnt == '0) begin
                        st <= ST_DONE;
                    end else begin
                        p_cnt <= p_cnt - 1'b1;
                        if (fwant < cfg.vmin) begin
                            st <= ST_DONE;
                        end else if (cfg.m_lo > cfg.m_hi) begin
                            st <= ST_STEP;
                        end else begin
                            m_cnt <= {1'b0, cfg.m_lo};
                            st    <= ST_NGO;
                        end
                    end
                end
                ST_NGO:  st <= ST_NWAIT;
                ST_NWAIT: begin
                    if (div_fin) begin
                        if (n_raw > freq_t'(cfg.n_hi)) begin
                            st <= ST_STEP;
                        end else begin
                            n_cur <= (n_raw < freq_t'(cfg.n_lo)) ? freq_t'(cfg.n_lo) : n_raw;
                            st    <= ST_VGO;
                        end
                    end
                end
                ST_VGO:  st <= ST_VWAIT;
                ST_VWAIT: begin
                    if (div_fin) begin
                        if (m_cnt >= {1'b0, cfg.m_hi}) begin
                            st <= ST_STEP;
                        end else begin
                            m_cnt <= m_cnt + 1'b1;
                            st    <= ST_NGO;
                        end
                    end
                end
                ST_STEP: begin
                    fwant <= fwant >> 1;
                    st    <= ST_OUTER;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy = !(st == ST_IDLE || st == ST_DONE);
    assign done = (st == ST_DONE);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(vco_khz) && $stable(m_sel) &&
                              $stable(n_sel) && $stable(p_sel)));

    // R8
    ign_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy && $stable(cfg)));

    // R7
    p_range_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> p_sel <= cfg.p_max);

    // R4
    coef_range_chk: assert property (@(posedge clk) disable iff (rst)
        (done && vco_khz != '0) |->
            (m_sel >= cfg.m_lo && m_sel <= cfg.m_hi &&
             n_sel >= cfg.n_lo && n_sel <= cfg.n_hi));

    // R10
    div_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy) |-> !div_busy);

endmodule

// File: tb/pll_coef_search_bench.sv
module pll_coef_search_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] ref_khz = '0, target_khz = '0, fmax_khz = '0, vco_min_khz = '0;
    logic [7:0]  m_lo = '0, m_hi = '0, n_lo = '0, n_hi = '0;
    logic [2:0]  p_max = '0;
    logic        busy, done;
    logic [7:0]  m_sel, n_sel;
    logic [2:0]  p_sel;
    logic [31:0] vco_khz;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string       tag;
        logic [7:0]  m;
        logic [7:0]  n;
        logic [2:0]  p;
        logic [31:0] v;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    pll_coef_search u_pll_coef_search (
        .clk(clk), .rst(rst), .start(start),
        .ref_khz(ref_khz), .target_khz(target_khz), .fmax_khz(fmax_khz),
        .vco_min_khz(vco_min_khz), .m_lo(m_lo), .m_hi(m_hi), .n_lo(n_lo),
        .n_hi(n_hi), .p_max(p_max), .busy(busy), .done(done),
        .m_sel(m_sel), .n_sel(n_sel), .p_sel(p_sel), .vco_khz(vco_khz)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Independent model of the search, from the requirements
    function automatic exp_t model(input string tag, input bit [31:0] rf, tg, fx, vm,
                                   input int ml, mh, nl, nh, pm);
        exp_t r;
        bit [31:0] fw, best, n, v, d, t;
        int p;
        r.tag = tag; r.m = '0; r.n = '0; r.p = '0; r.v = '0;
        fw = tg; p = 1;
        while (p <= pm) begin                                  // R2
            if ({1'b0, fw, 1'b0} > {2'b00, fx}) break;
            fw = fw << 1;
            p++;
        end
        if (fw < vm) fw = vm;                                  // R3
        if (fw > fx) fw = fx;
        best = 32'hFFFF_FFFF;
        while (p > 0) begin                                    // R7
            p--;
            if (fw < vm) break;
            for (int m = ml; m <= mh; m++) begin
                t = fw * 32'(m + 1);                           // R4
                t = t + (rf >> 1);
                n = t / rf - 32'd1;
                if (n > 32'(nh)) break;
                if (n < 32'(nl)) n = 32'(nl);
                t = rf * (n + 32'd1);                          // R5
                v = t / 32'(m + 1);
                d = (v < fw) ? fw - v : v - fw;
                if (d < best) begin                            // R6
                    best = d; r.m = 8'(m); r.n = n[7:0]; r.p = 3'(p); r.v = v;
                end
            end
            fw = fw >> 1;
            best = best >> 1;
        end
        return r;
    endfunction

    // Driver: pushes the expected item, then runs the request
    task automatic run_case(input string tag, input bit [31:0] rf, tg, fx, vm,
                            input int ml, mh, nl, nh, pm, input bit intrude);
        logic [31:0] hv;
        logic [7:0]  hm, hn;
        logic [2:0]  hp;
        exp_q.push_back(model(tag, rf, tg, fx, vm, ml, mh, nl, nh, pm));
        @(negedge clk);
        ref_khz = rf; target_khz = tg; fmax_khz = fx; vco_min_khz = vm;
        m_lo = 8'(ml); m_hi = 8'(mh); n_lo = 8'(nl); n_hi = 8'(nh); p_max = 3'(pm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R10", "busy after start", {31'd0, busy}, 32'd1);
        if (intrude) begin
            repeat (40) @(negedge clk);
            target_khz = tg * 3; m_lo = 8'd2; n_hi = 8'd255; ref_khz = rf + 32'd1000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1 && done == 1'b0, "R8", "busy after ignored start", {31'd0, busy}, 32'd1);
        end
        while (!done) @(negedge clk);
        hv = vco_khz; hm = m_sel; hn = n_sel; hp = p_sel;
        repeat (25) @(negedge clk);
        check(done == 1'b1 && vco_khz == hv && m_sel == hm && n_sel == hn && p_sel == hp,
              "R8", "result held", vco_khz, hv);
    endtask

    // Monitor: compares each result when done rises
    initial begin
        bit was_done = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && done && !was_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected result", vco_khz, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    check(m_sel == e.m, e.tag, "m_sel", {24'd0, m_sel}, {24'd0, e.m});
                    check(n_sel == e.n, e.tag, "n_sel", {24'd0, n_sel}, {24'd0, e.n});
                    check(p_sel == e.p, e.tag, "p_sel", {29'd0, p_sel}, {29'd0, e.p});
                    check(vco_khz == e.v, e.tag, "vco_khz", vco_khz, e.v);
                end
            end
            was_done = done;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy", {31'd0, busy}, 32'd0);
        check(done == 1'b0, "R1", "done", {31'd0, done}, 32'd0);
        check(vco_khz == '0 && m_sel == '0 && n_sel == '0 && p_sel == '0,
              "R1", "outputs", vco_khz, 32'd0);

        // R2 R4 R5 R6: several doublings, full search
        run_case("R2", 32'd14318, 32'd25175, 32'd220000, 32'd50000, 1, 31, 7, 127, 3, 1'b0);
        // R6: second reference and target
        run_case("R6", 32'd27000, 32'd108000, 32'd230000, 32'd50000, 1, 20, 7, 127, 3, 1'b0);
        // R3 R7: tiny target raised to the minimum; stops once below it
        run_case("R3", 32'd14318, 32'd1000, 32'd220000, 32'd50000, 1, 20, 7, 127, 2, 1'b0);
        // R3: target above fmax lowered to fmax, P recorded as 0
        run_case("R7", 32'd14318, 32'd300000, 32'd220000, 32'd50000, 1, 20, 7, 127, 3, 1'b0);
        // R4: large minimum N forces the raise
        run_case("R4", 32'd14318, 32'd25175, 32'd220000, 32'd50000, 1, 12, 100, 200, 3, 1'b0);
        // R9: every N above the maximum
        run_case("R9", 32'd14318, 32'd100000, 32'd220000, 32'd50000, 1, 31, 0, 2, 1, 1'b0);
        // R9: empty M range
        run_case("R9", 32'd14318, 32'd25175, 32'd220000, 32'd50000, 9, 3, 7, 127, 3, 1'b0);
        // R8: start during a search is ignored
        run_case("R8", 32'd27000, 32'd65000, 32'd220000, 32'd50000, 1, 16, 7, 127, 3, 1'b1);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R10", "all results seen", 32'(exp_q.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule